// File: doc/BRIEF.md
# Register-Mapped Program Memory Word Reader

This peripheral gives a processor core read access to its own read-only program word memory through a handful of byte-wide registers. Software writes a split word address into a low and a high address register, then writes a 1 to the start bit of the control register. The block fetches one word over a synchronous memory read port and places it into a low and a high data register. It then clears the start bit by itself, which software polls to learn that the word is ready.

The register bus is byte wide and uses a 3-bit register index, a write strobe, write data and combinational read data. The memory port presents an address together with a one-cycle read enable and expects the word on the following cycle. A read finishes a fixed two cycles after the start bit is set. The address is latched when the start bit is set, so software may prepare the next address while a fetch is still in flight.

Top module: `pmem_reader`

## Requirements
- R1: Index 0 is the low address register (8 bits, read/write). Index 1 is the high address register: bits 4:0 hold word address bits 12:8, and bits 7:5 ignore writes and read as 0.
- R2: Index 3 is the control register. A write with bit 0 = 1 sets the start bit. A write with bit 0 = 0 leaves the start bit unchanged, whether it is 0 or 1.
- R3: The start bit reads 1 on the two cycles after the clock edge that accepts the start write. It reads 0 after the second edge that follows. The data registers take the fetched word on that second edge.
- R4: Index 2 returns word bits 7:0. Index 4 returns word bits 13:8 in bits 5:0, and bits 7:6 read as 0.
- R5: In the control register, bit 7 always reads 1 and bits 6:1 always read 0.
- R6: Address writes made while a fetch is in flight are stored, but the fetch uses the address that was held when the start bit was set. The next read uses the new address.
- R7: Writes to indices 2 and 4 are ignored. The data registers change only when a fetch completes.
- R8: A synchronous active-low reset clears both address registers, both data registers and the start bit. This holds even when a fetch is in flight.
- R9: The memory read enable is high for exactly one cycle per accepted start. During that cycle it drives the latched address.
- R10: Indices 5 to 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_idx | input | 3 | Register index |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| mem_en | output | 1 | Memory read enable, one cycle per fetch |
| mem_addr | output | 13 | Memory word address |
| mem_rdata | input | 14 | Memory word, valid the cycle after mem_en |

## Verification
Reads are run at the address corners 0x0000 and 0x1FFF and at mixed interior addresses. The bench memory returns a word that differs at each address, so an error in splitting or joining the bytes shows up as a wrong value. One fetch has its low address rewritten right after the start, which separates latching at start from sampling the live register. Writes of 0 to the start bit, writes to the data registers, and writes to unmapped indices are each made while a fetch is in flight or while the block is idle. A reset in the middle of a fetch checks that no stale capture completes after it.

// File: rtl/pmr_pkg.sv
// Package: shared register indices and sequencer state for the program
// memory reader. Assumes a 3-bit register index on the byte bus.
package pmr_pkg;
    localparam int REG_IDX_W = 3;

    localparam logic [REG_IDX_W-1:0] IDX_ADDR_LO = 3'd0;
    localparam logic [REG_IDX_W-1:0] IDX_ADDR_HI = 3'd1;
    localparam logic [REG_IDX_W-1:0] IDX_DATA_LO = 3'd2;
    localparam logic [REG_IDX_W-1:0] IDX_CTRL    = 3'd3;
    localparam logic [REG_IDX_W-1:0] IDX_DATA_HI = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_CAPT  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/pmr_addr_regs.sv
// Module: pmr_addr_regs
// Holds the split word address written by software. The low byte is full
// width. The high register keeps only ADDR_W-BYTE_W bits and drops the rest.
// Assumes ADDR_W > BYTE_W and ADDR_W <= 2*BYTE_W.
module pmr_addr_regs #(
    parameter int ADDR_W = 13,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - BYTE_W;

    logic [BYTE_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;

    // Purpose: store software writes to the low and high address bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (wr_lo) lo_q <= wdata;
            if (wr_hi) hi_q <= wdata[HI_W-1:0];
        end
    end

    // Purpose: join the two bytes into the word address.
    always_comb addr = {hi_q, lo_q};
endmodule

// File: rtl/pmr_seq.sv
// Module: pmr_seq
// Two-step fetch sequencer. On a start request while idle it latches the
// address. It then issues one memory read cycle, and on the next cycle it
// pulses the capture enable. Assumes the memory returns data the cycle
// after its enable.
module pmr_seq
    import pmr_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              busy,
    output logic              mem_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              cap_en
);
    seq_state_t        state_q;
    logic [ADDR_W-1:0] lat_q;

    // Purpose: advance the fetch state and latch the address at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lat_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_req) begin
                    state_q <= ST_ISSUE;
                    lat_q   <= addr_in;
                end
                ST_ISSUE: state_q <= ST_CAPT;
                ST_CAPT:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: decode the state into the strobes and the memory address.
    always_comb begin
        busy     = (state_q != ST_IDLE);
        mem_en   = (state_q == ST_ISSUE);
        cap_en   = (state_q == ST_CAPT);
        mem_addr = lat_q;
    end

    // R3: a read is busy for exactly two cycles
    p_two_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> (busy ##1 !busy));

    // R9: the memory enable lasts one cycle
    p_single_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> !mem_en);

    // R6: the latched address holds across a fetch
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr));
endmodule

// File: rtl/pmr_data_regs.sv
// Module: pmr_data_regs
// Holds the last fetched word. It loads only on the capture strobe and has
// no bus write path. Assumes mem_rdata is valid while cap_en is high.
module pmr_data_regs #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] word
);
    // Purpose: capture the memory word when a fetch completes.
    always_ff @(posedge clk) begin
        if (!rst_n)      word <= '0;
        else if (cap_en) word <= mem_rdata;
    end

    // R7: the word changes only on capture
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(word));
endmodule

// File: rtl/pmem_reader.sv
// Module: pmem_reader (top)
// Byte-wide register front end for the program memory reader. It decodes
// bus writes, builds the combinational read mux, and wires the address,
// sequencer and data blocks together. Assumes a single-cycle write strobe
// and a memory with one cycle of read latency.
module pmem_reader
    import pmr_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 14,
    parameter int BYTE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_IDX_W-1:0] reg_idx,
    input  logic                 reg_we,
    input  logic [BYTE_W-1:0]    reg_wdata,
    output logic [BYTE_W-1:0]    reg_rdata,
    output logic                 mem_en,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic [DATA_W-1:0]    mem_rdata
);
    localparam int AHI_W = ADDR_W - BYTE_W;
    localparam int DHI_W = DATA_W - BYTE_W;

    logic              wr_lo, wr_hi, start_req;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] word;
    logic              busy, cap_en;

    // Purpose: decode bus writes into register strobes.
    always_comb begin
        wr_lo     = reg_we && (reg_idx == IDX_ADDR_LO);
        wr_hi     = reg_we && (reg_idx == IDX_ADDR_HI);
        start_req = reg_we && (reg_idx == IDX_CTRL) && reg_wdata[0];
    end

    pmr_addr_regs #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wdata(reg_wdata), .addr(addr)
    );

    pmr_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .addr_in(addr),
        .busy(busy), .mem_en(mem_en), .mem_addr(mem_addr), .cap_en(cap_en)
    );

    pmr_data_regs #(.DATA_W(DATA_W)) u_data (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .mem_rdata(mem_rdata),
        .word(word)
    );

    // Purpose: select the register that the bus reads, zero-filling unused bits.
    always_comb begin
        unique case (reg_idx)
            IDX_ADDR_LO: reg_rdata = addr[BYTE_W-1:0];
            IDX_ADDR_HI: reg_rdata = {{(BYTE_W-AHI_W){1'b0}}, addr[ADDR_W-1:BYTE_W]};
            IDX_DATA_LO: reg_rdata = word[BYTE_W-1:0];
            IDX_DATA_HI: reg_rdata = {{(BYTE_W-DHI_W){1'b0}}, word[DATA_W-1:BYTE_W]};
            IDX_CTRL:    reg_rdata = {1'b1, {(BYTE_W-2){1'b0}}, busy};
            default:     reg_rdata = '0;
        endcase
    end

    // R2: an accepted start write sets the start bit
    p_start_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !busy) |=> (reg_idx != IDX_CTRL || reg_rdata[0]));

    // R5: fixed control bits
    p_ctrl_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == IDX_CTRL) |-> (reg_rdata[BYTE_W-1:1] == {1'b1, {(BYTE_W-2){1'b0}}}));

    // R1: unused high address bits read as zero
    p_addr_hi_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == IDX_ADDR_HI) |-> (reg_rdata[BYTE_W-1:AHI_W] == '0));

    // R10: unmapped indices read as zero
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx > IDX_DATA_HI) |-> (reg_rdata == '0));
endmodule

// File: tb/test_pmem_reader.sv
// Scoreboard bench for pmem_reader. A driver task starts reads and pushes
// the expected word. A monitor task pops it and compares it with what the
// data registers return over the bus.
module test_pmem_reader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_idx = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       mem_en;
    logic [12:0] mem_addr;
    logic [13:0] mem_rdata = '0;

    int n_checks = 0;
    int n_fail = 0;
    logic [13:0] exp_q[$];

    always #2 clk = ~clk;  // 250 MHz

    pmem_reader i_pmem_reader (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_en(mem_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    function automatic logic [13:0] rom_word(input logic [12:0] a);
        logic [13:0] x;
        x = {1'b0, a} * 14'd113;
        return (x ^ {4'b0, a[12:3]} ^ 14'h2A5);
    endfunction

    // Bench memory: synchronous, one cycle of read latency.
    always @(posedge clk) if (mem_en) mem_rdata <= rom_word(mem_addr);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [7:0] d);
        @(negedge clk);
        reg_idx = idx; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [7:0] d);
        reg_idx = idx;
        #1;
        d = reg_rdata;
    endtask

    // Driver: load the address, start, push the expected word.
    task automatic start_read(input logic [12:0] a);
        wr(3'd0, a[7:0]);
        wr(3'd1, {3'b0, a[12:8]});
        wr(3'd3, 8'h01);
        exp_q.push_back(rom_word(a));
    endtask

    task automatic wait_done();
        @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pop the expected word and compare it with the data registers.
    task automatic monitor_pop(input string req);
        logic [7:0] lo, hi;
        logic [13:0] e;
        e = exp_q.pop_front();
        rd(3'd2, lo);
        rd(3'd4, hi);
        check({req, " data lo"}, lo, e[7:0]);
        check({req, " data hi"}, hi, {2'b00, e[13:8]});
    endtask

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=finish");
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
                $finish;
            end
        join_none
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        rd(3'd0, v); check("R8 addr lo", v, 8'h00);
        rd(3'd1, v); check("R8 addr hi", v, 8'h00);
        rd(3'd2, v); check("R8 data lo", v, 8'h00);
        rd(3'd4, v); check("R8 data hi", v, 8'h00);
        rd(3'd3, v); check("R8 ctrl", v, 8'h80);

        // R1 address registers
        wr(3'd0, 8'hA5); rd(3'd0, v); check("R1 addr lo", v, 8'hA5);
        wr(3'd1, 8'hFF); rd(3'd1, v); check("R1 addr hi masked", v, 8'h1F);

        // R2 write of 0 while idle
        wr(3'd3, 8'hFE); rd(3'd3, v); check("R2 zero write idle", v, 8'h80);

        // R3/R4/R9 read at top corner, with timing
        start_read(13'h1FFF);
        rd(3'd3, v); check("R3 busy cycle1", v, 8'h81);
        @(negedge clk); rd(3'd3, v); check("R3 busy cycle2", v, 8'h81);
        @(negedge clk); rd(3'd3, v); check("R3 done", v, 8'h80);
        monitor_pop("R4 corner 1FFF");

        // R3 read at address 0
        start_read(13'h0000);
        wait_done(); rd(3'd3, v); check("R3 done addr0", v, 8'h80);
        monitor_pop("R3 addr0");

        // R2 write 0 during a fetch does not clear the start bit
        start_read(13'h0ABC);
        @(negedge clk);
        reg_idx = 3'd3; reg_we = 1'b1; reg_wdata = 8'h00;
        #1; v = reg_rdata; check("R2 still busy", v, 8'h81);
        @(negedge clk); reg_we = 1'b0;
        rd(3'd3, v); check("R2 done after zero write", v, 8'h80);
        monitor_pop("R2 interior");

        // R6 address rewrite during fetch; R7/R10 writes during fetch
        start_read(13'h1234);
        reg_idx = 3'd0; reg_we = 1'b1; reg_wdata = 8'h77;
        @(negedge clk);
        reg_idx = 3'd2; reg_wdata = 8'hEE;
        @(negedge clk);
        reg_idx = 3'd5; reg_wdata = 8'h99;
        @(negedge clk);
        reg_we = 1'b0;
        monitor_pop("R6 latched address");
        rd(3'd0, v); check("R6 new addr stored", v, 8'h77);
        rd(3'd5, v); check("R10 unmapped reads 0", v, 8'h00);
        rd(3'd7, v); check("R10 idx7 reads 0", v, 8'h00);

        // R6 next read uses the new address
        wr(3'd3, 8'h01);
        exp_q.push_back(rom_word(13'h1277));
        wait_done();
        monitor_pop("R6 next read");

        // R7 writes to data registers while idle
        wr(3'd2, 8'h5A); wr(3'd4, 8'hC3);
        exp_q.push_back(rom_word(13'h1277));
        monitor_pop("R7 ignored");
        rd(3'd0, v); check("R10 addr lo intact", v, 8'h77);
        rd(3'd1, v); check("R10 addr hi intact", v, 8'h12);

        // R8 reset during a fetch
        start_read(13'h0F0F);
        void'(exp_q.pop_back());
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(3'd3, v); check("R8 ctrl after mid reset", v, 8'h80);
        rd(3'd2, v); check("R8 data lo after mid reset", v, 8'h00);
        rd(3'd4, v); check("R8 data hi after mid reset", v, 8'h00);
        rd(3'd0, v); check("R8 addr lo after mid reset", v, 8'h00);

        // Several more patterns
        for (int i = 0; i < 6; i++) begin
            start_read(13'(i * 1531 + 7));
            wait_done();
            monitor_pop("R3 sweep");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule